// File: doc/BRIEF.md
# Serial Command Register Interface

This block is the control port of an audio processing core. A host writes one-byte commands to it over a serial link. The top nibble of the command byte picks an opcode group and the low nibble carries a sub-field. A group may expect zero, one, two or three trailing data bytes. The block collects the bytes and checks that the count matches the group. It then updates a bank of control registers that sit on its output ports. Each register has a defined reset value.

A static mode pin picks one of two front ends, and both deliver the same byte stream. In three-wire mode an active-low select frames each command, and bits are taken MSB first on the rising edge of the shift clock. The rising edge of the select ends the command. In I2C mode the block is a write-only target at address byte 0xD8, and each command sits between its own START and STOP. The STOP ends the command.

All serial inputs are sampled by the block clock, which must run several times faster than the shift clock. A command takes effect only when its frame closes with exactly the expected number of bytes.

Top module: `cmd_port`

## Requirements
- R1: `wire3_sel_i` high selects three-wire mode and low selects I2C mode. Traffic that follows the protocol of the front end that is not selected changes no register.
- R2: In three-wire mode, bits are taken MSB first on rising `scl_i` edges while `cs_ni` is low. A rising `cs_ni` closes the command, and a valid command's register update is visible at the ports within four clock cycles of that edge.
- R3: Group nibbles 0x0 to 0xA and 0xE to 0xF expect no data byte, 0xB expects two, 0xC expects three and 0xD expects one. A frame that closes with fewer or more bytes than that changes no register and raises no pulse.
- R4: For groups 0x1 to 0xA, the command's low nibble is stored in `ctl_nib_o[4*(g-1)+3 : 4*(g-1)]` for group g. Group 0x0 raises `boot_o` for exactly one cycle. Groups 0xE and 0xF change nothing.
- R5: Group 0xB stores its two data bytes, first byte as the high byte, into `atten_a_o` for sub-field 0, `atten_b_o` for 1, `key2_o` for 2 and `ext_port_o` for 3. Sub-fields 4 to 15 change nothing.
- R6: Group 0xC raises `coef_we_o` for exactly one cycle. With data bytes d2, d1, d0 in arrival order, `coef_addr_o` = {cmd[0], d2[7:2]} and `coef_dat_o` = {d2[1:0], d1, d0}. Both hold until the next such command.
- R7: Group 0xD stores the low nibble in `mode_ctl_o` and its data byte in `mode_dat_o`.
- R8: Reset values: `ctl_nib_o` group 6 = 5, group 7 = 2, group 0xA = 8 and every other group 0; `atten_a_o` = `atten_b_o` = 0x2000; `key2_o` = `ext_port_o` = 0; `mode_ctl_o` = 0x1; `mode_dat_o` = 0; `coef_addr_o`, `coef_dat_o`, `coef_we_o`, `boot_o` and `sda_oe_o` = 0.
- R9: In I2C mode, after START the block drives `sda_oe_o` high through the ninth clock of the address byte 0xD8 and of every data byte that follows it. For any other address byte it stays low for that byte and for the rest of the transfer.
- R10: In I2C mode, a STOP closes the command, and a valid command updates the registers as in R4 to R7.
- R11: `sda_oe_o` stays low while three-wire mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wire3_sel_i | input | 1 | 1 = three-wire front end, 0 = I2C front end |
| cs_ni | input | 1 | Three-wire frame select, active low |
| scl_i | input | 1 | Serial shift clock |
| sda_i | input | 1 | Serial data line (bus level) |
| sda_oe_o | output | 1 | Pull data line low (I2C acknowledge) |
| boot_o | output | 1 | One-cycle coefficient re-initialise request |
| ctl_nib_o | output | 40 | Low nibbles of groups 0x1 to 0xA, group g at bits 4(g-1) upward |
| atten_a_o | output | 16 | Attenuator A word |
| atten_b_o | output | 16 | Attenuator B word |
| key2_o | output | 16 | Secondary key control word |
| ext_port_o | output | 16 | Parallel extension output word |
| mode_ctl_o | output | 4 | Operating mode nibble |
| mode_dat_o | output | 8 | Operating mode data byte |
| coef_we_o | output | 1 | Coefficient write strobe |
| coef_addr_o | output | 7 | Coefficient write address |
| coef_dat_o | output | 18 | Coefficient write data |

## Verification
A wrong byte count or a stale command latch shows up as a register that fails to move, or that moves on a truncated frame. It can be seen a few cycles after the closing select edge or STOP. A mis-tracked I2C bit phase shows up at the very next ninth clock, as an acknowledge that is missing or misplaced on `sda_oe_o`. A leaked data shift ends up as a wrong value in whichever word or coefficient field the command targets, and that value stays there until the next command to that field.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;
  localparam int NIB_GROUPS = 10;
  localparam int NIB_W      = 4 * NIB_GROUPS;
  localparam int WORD_W     = 16;
  localparam int WORD_CNT   = 4;
  localparam int COEF_AW    = 7;
  localparam int COEF_DW    = 18;
  localparam int MAX_DATA   = 3;
  localparam int SR_W       = 8 * MAX_DATA;
  localparam int CNT_W      = 3;

  localparam logic [3:0] GRP_BOOT = 4'h0;
  localparam logic [3:0] GRP_WORD = 4'hB;
  localparam logic [3:0] GRP_COEF = 4'hC;
  localparam logic [3:0] GRP_MODE = 4'hD;

  localparam logic [3:0] MODE_CTL_RST = 4'h1;

  typedef enum logic [2:0] {
    I_IDLE, I_ADDR, I_DATA, I_ACKW, I_ACK, I_SKIP
  } i2c_st_e;

  function automatic logic [1:0] data_len(input logic [3:0] grp);
    case (grp)
      GRP_WORD: return 2'd2;
      GRP_COEF: return 2'd3;
      GRP_MODE: return 2'd1;
      default:  return 2'd0;
    endcase
  endfunction

  function automatic logic [3:0] nib_reset(input int grp);
    case (grp)
      6:       return 4'h5;
      7:       return 4'h2;
      10:      return 4'h8;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] word_reset(input int idx);
    return (idx < 2) ? WORD_W'(16'h2000) : '0;
  endfunction
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/cp_wire3_rx.sv
module cp_wire3_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       sel_n_i,
  input  logic       sel_rise_i,
  input  logic       scl_rise_i,
  input  logic       sda_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       frame_end_o
);
  logic [6:0] sr_q;
  logic [2:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      bit_q      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!en_i || sel_n_i) begin
        bit_q <= '0;
      end else if (scl_rise_i) begin
        sr_q  <= {sr_q[5:0], sda_i};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sr_q, sda_i};
        end
      end
    end
  end

  assign frame_end_o = en_i & sel_rise_i;
endmodule

// File: rtl/cp_i2c_rx.sv
module cp_i2c_rx import cmd_port_pkg::*; #(
  parameter logic [7:0] DEV_ADDR = 8'hD8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       frame_end_o,
  output logic       sda_oe_o
);
  i2c_st_e    st_q;
  logic [6:0] sr_q;
  logic [2:0] bit_q;
  logic       ack_q;
  logic       in_frame_q;
  logic [7:0] nxt_byte;

  assign nxt_byte = {sr_q, sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= I_IDLE;
      sr_q       <= '0;
      bit_q      <= '0;
      ack_q      <= 1'b0;
      in_frame_q <= 1'b0;
      sda_oe_o   <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (!en_i) begin
        st_q       <= I_IDLE;
        bit_q      <= '0;
        in_frame_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else if (start_i) begin
        st_q       <= I_ADDR;
        bit_q      <= '0;
        in_frame_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        st_q       <= I_IDLE;
        in_frame_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else begin
        unique case (st_q)
          I_ADDR, I_DATA: if (scl_rise_i) begin
            sr_q  <= nxt_byte[6:0];
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              st_q <= I_ACKW;
              if (st_q == I_ADDR) begin
                ack_q      <= (nxt_byte == DEV_ADDR);
                in_frame_q <= (nxt_byte == DEV_ADDR);
              end else begin
                ack_q      <= 1'b1;
                byte_vld_o <= 1'b1;
                byte_o     <= nxt_byte;
              end
            end
          end
          I_ACKW: if (scl_fall_i) begin
            sda_oe_o <= ack_q;
            st_q     <= I_ACK;
          end
          I_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            bit_q    <= '0;
            st_q     <= ack_q ? I_DATA : I_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // repeated START also closes an open command
  assign frame_end_o = en_i & in_frame_q & (start_i | stop_i);
endmodule

// File: rtl/cp_decode.sv
module cp_decode import cmd_port_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic               frame_end_i,
  input  logic               abort_i,
  output logic               boot_o,
  output logic [NIB_W-1:0]   ctl_nib_o,
  output logic [WORD_W-1:0]  atten_a_o,
  output logic [WORD_W-1:0]  atten_b_o,
  output logic [WORD_W-1:0]  key2_o,
  output logic [WORD_W-1:0]  ext_port_o,
  output logic [3:0]         mode_ctl_o,
  output logic [7:0]         mode_dat_o,
  output logic               coef_we_o,
  output logic [COEF_AW-1:0] coef_addr_o,
  output logic [COEF_DW-1:0] coef_dat_o
);
  logic [7:0]       cmd_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SR_W-1:0]  sr_q;
  logic [3:0]       grp, sub;
  logic             commit;

  assign grp    = cmd_q[7:4];
  assign sub    = cmd_q[3:0];
  assign commit = frame_end_i && (cnt_q == ({1'b0, data_len(grp)} + 3'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (frame_end_i || abort_i) begin
      cnt_q <= '0;
    end else if (byte_vld_i) begin
      if (cnt_q == '0) cmd_q <= byte_i;
      else             sr_q  <= {sr_q[SR_W-9:0], byte_i};
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  logic [3:0] nib_q [NIB_GROUPS];
  for (genvar g = 0; g < NIB_GROUPS; g++) begin : g_nib
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          nib_q[g] <= nib_reset(g + 1);
      else if (commit && grp == 4'(g + 1))  nib_q[g] <= sub;
    end
    assign ctl_nib_o[4*g +: 4] = nib_q[g];
  end

  logic [WORD_W-1:0] word_q [WORD_CNT];
  for (genvar k = 0; k < WORD_CNT; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_q[k] <= word_reset(k);
      else if (commit && grp == GRP_WORD && sub == 4'(k))
        word_q[k] <= sr_q[WORD_W-1:0];
    end
  end
  assign atten_a_o  = word_q[0];
  assign atten_b_o  = word_q[1];
  assign key2_o     = word_q[2];
  assign ext_port_o = word_q[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_o      <= 1'b0;
      coef_we_o   <= 1'b0;
      coef_addr_o <= '0;
      coef_dat_o  <= '0;
      mode_ctl_o  <= MODE_CTL_RST;
      mode_dat_o  <= '0;
    end else begin
      boot_o    <= commit && grp == GRP_BOOT;
      coef_we_o <= commit && grp == GRP_COEF;
      if (commit && grp == GRP_COEF) begin
        coef_addr_o <= {sub[0], sr_q[SR_W-1 -: COEF_AW-1]};
        coef_dat_o  <= sr_q[COEF_DW-1:0];
      end
      if (commit && grp == GRP_MODE) begin
        mode_ctl_o <= sub;
        mode_dat_o <= sr_q[7:0];
      end
    end
  end
endmodule

// File: rtl/cmd_port.sv
module cmd_port import cmd_port_pkg::*; #(
  parameter logic [7:0] DEV_ADDR    = 8'hD8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wire3_sel_i,
  input  logic               cs_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic               boot_o,
  output logic [NIB_W-1:0]   ctl_nib_o,
  output logic [WORD_W-1:0]  atten_a_o,
  output logic [WORD_W-1:0]  atten_b_o,
  output logic [WORD_W-1:0]  key2_o,
  output logic [WORD_W-1:0]  ext_port_o,
  output logic [3:0]         mode_ctl_o,
  output logic [7:0]         mode_dat_o,
  output logic               coef_we_o,
  output logic [COEF_AW-1:0] coef_addr_o,
  output logic [COEF_DW-1:0] coef_dat_o
);
  logic [3:0] pin_s, prev_q;
  logic       w3_mode, cs_s, scl_s, sda_s;
  logic       scl_rise, scl_fall, cs_rise, start, stop, mode_chg;

  cp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST(4'hF)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wire3_sel_i, cs_ni, scl_i, sda_i}),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 4'hF;
    else         prev_q <= pin_s;
  end

  assign {w3_mode, cs_s, scl_s, sda_s} = pin_s;
  assign scl_rise = scl_s & ~prev_q[1];
  assign scl_fall = ~scl_s & prev_q[1];
  assign cs_rise  = cs_s & ~prev_q[2];
  assign mode_chg = w3_mode ^ prev_q[3];
  assign start    = scl_s & prev_q[1] & ~sda_s & prev_q[0];
  assign stop     = scl_s & prev_q[1] & sda_s & ~prev_q[0];

  logic       w3_vld, i2c_vld, w3_end, i2c_end, byte_vld, frame_end;
  logic [7:0] w3_byte, i2c_byte, byte_d;

  cp_wire3_rx u_w3 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (w3_mode),
    .sel_n_i    (cs_s),
    .sel_rise_i (cs_rise),
    .scl_rise_i (scl_rise),
    .sda_i      (sda_s),
    .byte_vld_o (w3_vld),
    .byte_o     (w3_byte),
    .frame_end_o(w3_end)
  );

  cp_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_i2c (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (~w3_mode),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .start_i    (start),
    .stop_i     (stop),
    .byte_vld_o (i2c_vld),
    .byte_o     (i2c_byte),
    .frame_end_o(i2c_end),
    .sda_oe_o   (sda_oe_o)
  );

  assign byte_vld  = w3_mode ? w3_vld  : i2c_vld;
  assign byte_d    = w3_mode ? w3_byte : i2c_byte;
  assign frame_end = w3_mode ? w3_end  : i2c_end;

  cp_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_d),
    .frame_end_i(frame_end),
    .abort_i    (mode_chg),
    .boot_o     (boot_o),
    .ctl_nib_o  (ctl_nib_o),
    .atten_a_o  (atten_a_o),
    .atten_b_o  (atten_b_o),
    .key2_o     (key2_o),
    .ext_port_o (ext_port_o),
    .mode_ctl_o (mode_ctl_o),
    .mode_dat_o (mode_dat_o),
    .coef_we_o  (coef_we_o),
    .coef_addr_o(coef_addr_o),
    .coef_dat_o (coef_dat_o)
  );
endmodule

// File: rtl/cmd_port_chk.sv
module cmd_port_chk import cmd_port_pkg::*; (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_end_i,
  input logic               w3_mode_i,
  input logic               scl_s_i,
  input logic               sda_oe_i,
  input logic               boot_i,
  input logic               coef_we_i,
  input logic [NIB_W-1:0]   ctl_nib_i,
  input logic [WORD_W-1:0]  atten_a_i,
  input logic [WORD_W-1:0]  atten_b_i,
  input logic [WORD_W-1:0]  key2_i,
  input logic [WORD_W-1:0]  ext_port_i,
  input logic [3:0]         mode_ctl_i,
  input logic [7:0]         mode_dat_i
);
  // R4
  boot_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_i |=> !boot_i);

  // R6
  coef_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_we_i |=> !coef_we_i);

  // R3
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({ctl_nib_i, atten_a_i, atten_b_i, key2_i, ext_port_i, mode_ctl_i, mode_dat_i})
      |-> $past(frame_end_i));

  // R11
  w3_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w3_mode_i && $past(w3_mode_i)) |-> !sda_oe_i);

  // R9
  ack_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_s_i);
endmodule

bind cmd_port cmd_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_end_i(frame_end),
  .w3_mode_i  (w3_mode),
  .scl_s_i    (scl_s),
  .sda_oe_i   (sda_oe_o),
  .boot_i     (boot_o),
  .coef_we_i  (coef_we_o),
  .ctl_nib_i  (ctl_nib_o),
  .atten_a_i  (atten_a_o),
  .atten_b_i  (atten_b_o),
  .key2_i     (key2_o),
  .ext_port_i (ext_port_o),
  .mode_ctl_i (mode_ctl_o),
  .mode_dat_i (mode_dat_o)
);

// File: tb/sim_cmd_port.sv
module sim_cmd_port;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int WDOG       = 195000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic w3_sel = 1'b1, cs_n = 1'b1, scl = 1'b1, sda_drv = 1'b1;
  logic        sda_oe, boot, coef_we;
  logic [39:0] ctl_nib;
  logic [15:0] atten_a, atten_b, key2, ext_port;
  logic [3:0]  mode_ctl;
  logic [7:0]  mode_dat;
  logic [6:0]  coef_addr;
  logic [17:0] coef_dat;
  logic        sda_line;

  assign sda_line = sda_drv & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .wire3_sel_i(w3_sel), .cs_ni(cs_n),
    .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe), .boot_o(boot),
    .ctl_nib_o(ctl_nib), .atten_a_o(atten_a), .atten_b_o(atten_b),
    .key2_o(key2), .ext_port_o(ext_port), .mode_ctl_o(mode_ctl),
    .mode_dat_o(mode_dat), .coef_we_o(coef_we), .coef_addr_o(coef_addr),
    .coef_dat_o(coef_dat)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int boot_seen = 0, coef_seen = 0, w3_oe_seen = 0;

  logic [3:0]  e_nib [1:10];
  logic [15:0] e_word [4];
  logic [3:0]  e_mctl;
  logic [7:0]  e_mdat;
  logic [6:0]  e_caddr;
  logic [17:0] e_cdat;
  int          e_boot = 0, e_coef = 0;

  always @(negedge clk) begin
    if (boot) boot_seen++;
    if (coef_we) coef_seen++;
    if (w3_sel && sda_oe) w3_oe_seen++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_flat();
    logic [39:0] f;
    for (int g = 1; g <= 10; g++) f[4*(g-1) +: 4] = e_nib[g];
    return f;
  endfunction

  task automatic check_all(input string tag);
    chk_eq({tag, " nib"}, 64'(ctl_nib), 64'(exp_flat()));
    chk_eq({tag, " atten_a"}, 64'(atten_a), 64'(e_word[0]));
    chk_eq({tag, " atten_b"}, 64'(atten_b), 64'(e_word[1]));
    chk_eq({tag, " key2"}, 64'(key2), 64'(e_word[2]));
    chk_eq({tag, " ext"}, 64'(ext_port), 64'(e_word[3]));
    chk_eq({tag, " mode_ctl"}, 64'(mode_ctl), 64'(e_mctl));
    chk_eq({tag, " mode_dat"}, 64'(mode_dat), 64'(e_mdat));
    chk_eq({tag, " boot count"}, 64'(boot_seen), 64'(e_boot));
    chk_eq({tag, " coef count"}, 64'(coef_seen), 64'(e_coef));
    chk_eq({tag, " coef_addr"}, 64'(coef_addr), 64'(e_caddr));
    chk_eq({tag, " coef_dat"}, 64'(coef_dat), 64'(e_cdat));
  endtask

  // bytes[31:24] = command, later bytes follow in arrival order
  task automatic model(input logic [31:0] b, input int n);
    logic [3:0] g, s;
    int need;
    g = b[31:28];
    s = b[27:24];
    need = (g == 4'hB) ? 2 : (g == 4'hC) ? 3 : (g == 4'hD) ? 1 : 0;
    if (n != need + 1) return;
    if (g == 4'h0) e_boot++;
    else if (g <= 4'hA) e_nib[g] = s;
    else if (g == 4'hB) begin
      if (s < 4) e_word[s[1:0]] = b[23:8];
    end else if (g == 4'hC) begin
      e_coef++;
      e_caddr = {s[0], b[23:18]};
      e_cdat  = b[17:0];
    end else if (g == 4'hD) begin
      e_mctl = s;
      e_mdat = b[23:16];
    end
  endtask

  task automatic w3_send(input logic [31:0] b, input int n);
    logic [7:0] cur;
    cs_n = 1'b0;
    tick(H);
    for (int i = 0; i < n; i++) begin
      cur = b[31-8*i -: 8];
      for (int j = 7; j >= 0; j--) begin
        scl = 1'b0; tick(1);
        sda_drv = cur[j]; tick(H);
        scl = 1'b1; tick(H);
      end
    end
    scl = 1'b0; tick(1);
    sda_drv = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    cs_n = 1'b1;
    tick(6);
  endtask

  task automatic i2c_byte(input logic [7:0] v, input bit exp_ack, input string tag);
    for (int j = 7; j >= 0; j--) begin
      sda_drv = v[j]; tick(H);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(1);
    end
    sda_drv = 1'b1; tick(H);
    scl = 1'b1; tick(H/2);
    chk_eq(tag, 64'(sda_oe), 64'(exp_ack));
    tick(H/2);
    scl = 1'b0; tick(1);
  endtask

  task automatic i2c_cmd(input logic [7:0] addr, input logic [31:0] b, input int n,
                         input bit exp_ack);
    sda_drv = 1'b1; scl = 1'b1; tick(H);
    sda_drv = 1'b0; tick(H);
    scl = 1'b0; tick(H);
    i2c_byte(addr, exp_ack, "R9 address ack");
    for (int i = 0; i < n; i++) i2c_byte(b[31-8*i -: 8], exp_ack, "R9 data ack");
    sda_drv = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    sda_drv = 1'b1; tick(H + 6);
  endtask

  initial begin
    for (int g = 1; g <= 10; g++) e_nib[g] = (g == 6) ? 4'h5 : (g == 7) ? 4'h2 : (g == 10) ? 4'h8 : 4'h0;
    e_word[0] = 16'h2000; e_word[1] = 16'h2000; e_word[2] = 16'h0; e_word[3] = 16'h0;
    e_mctl = 4'h1; e_mdat = 8'h0; e_caddr = '0; e_cdat = '0;

    tick(4);
    chk_eq("R8 sda_oe in reset", 64'(sda_oe), 64'h0);
    check_all("R8 in reset");
    rst_n = 1'b1;
    tick(6);
    check_all("R8 after reset");

    // R4 / R2: every one-nibble group and value over three-wire
    for (int g = 1; g <= 10; g++)
      for (int v = 0; v < 16; v++) begin
        logic [31:0] b;
        b = {4'(g), 4'(v), 24'h0};
        w3_send(b, 1);
        model(b, 1);
        chk_eq("R4 R2 nibble group", 64'(ctl_nib), 64'(exp_flat()));
      end

    // R4: boot pulses, ignored groups E and F
    w3_send(32'h0000_0000, 1); model(32'h0000_0000, 1);
    w3_send(32'h0700_0000, 1); model(32'h0700_0000, 1);
    w3_send(32'hE300_0000, 1); model(32'hE300_0000, 1);
    w3_send(32'hF900_0000, 1); model(32'hF900_0000, 1);
    check_all("R4 boot and ignored groups");

    // R5: every sub-field of the two-byte group
    for (int k = 0; k < 16; k++) begin
      logic [31:0] b;
      b = {4'hB, 4'(k), 16'(16'h1357 * (k + 1) ^ 16'hA0C5), 8'h0};
      w3_send(b, 3);
      model(b, 3);
      check_all("R5 word write");
    end

    // R6: coefficient writes, both address MSB values
    for (int i = 0; i < 8; i++) begin
      logic [31:0] b;
      b = {4'hC, 4'(i * 3), 24'(24'h2B3C5 * (i + 1) ^ 24'hA5A5A5)};
      w3_send(b, 4);
      model(b, 4);
      check_all("R6 coef write");
    end

    // R7: mode command
    for (int i = 0; i < 16; i++) begin
      logic [31:0] b;
      b = {4'hD, 4'(i), 8'(i * 17 ^ 8'h5A), 16'h0};
      w3_send(b, 2);
      model(b, 2);
      check_all("R7 mode write");
    end

    // R3: wrong byte counts discarded
    w3_send(32'hB3AB_CD00, 2); model(32'hB3AB_CD00, 2);
    w3_send(32'hB3AB_CDEF, 4); model(32'hB3AB_CDEF, 4);
    w3_send(32'hC1FF_EE00, 3); model(32'hC1FF_EE00, 3);
    w3_send(32'hD600_0000, 1); model(32'hD600_0000, 1);
    w3_send(32'hD677_8800, 3); model(32'hD677_8800, 3);
    w3_send(32'h2977_0000, 2); model(32'h2977_0000, 2);
    w3_send(32'h0055_0000, 2); model(32'h0055_0000, 2);
    check_all("R3 byte count mismatch");

    chk_eq("R11 no ack drive in three-wire mode", 64'(w3_oe_seen), 64'h0);

    // I2C mode
    w3_sel = 1'b0;
    tick(10);

    // R9 / R10: every address byte
    for (int a = 0; a < 256; a++) begin
      logic [31:0] b;
      b = {4'h3, 4'(a), 24'h0};
      i2c_cmd(8'(a), b, 1, a == 8'hD8);
      if (a == 8'hD8) model(b, 1);
      chk_eq("R9 R10 address filter", 64'(ctl_nib), 64'(exp_flat()));
    end

    i2c_cmd(8'hD8, 32'hB2C3_5A00, 3, 1'b1); model(32'hB2C3_5A00, 3);
    i2c_cmd(8'hD8, 32'hB39E_0100, 3, 1'b1); model(32'hB39E_0100, 3);
    i2c_cmd(8'hD8, 32'hC17F_3C99, 4, 1'b1); model(32'hC17F_3C99, 4);
    i2c_cmd(8'hD8, 32'hDA3C_0000, 2, 1'b1); model(32'hDA3C_0000, 2);
    i2c_cmd(8'hD8, 32'h0000_0000, 1, 1'b1); model(32'h0000_0000, 1);
    check_all("R10 I2C multi-byte");

    i2c_cmd(8'hD8, 32'hB166_0000, 2, 1'b1); model(32'hB166_0000, 2);
    i2c_cmd(8'hD8, 32'hD111_2200, 3, 1'b1); model(32'hD111_2200, 3);
    check_all("R3 R10 I2C truncated or long");

    // R1: other front end's traffic ignored
    w3_send(32'h1F00_0000, 1);
    check_all("R1 three-wire traffic in I2C mode");
    w3_sel = 1'b1;
    tick(10);
    i2c_cmd(8'hD8, 32'h1E00_0000, 1, 1'b0);
    check_all("R1 I2C traffic in three-wire mode");
    chk_eq("R11 no ack drive after mode return", 64'(w3_oe_seen), 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule